// File: doc/BRIEF.md
# Serial 32-bit Command Word Receiver

This block takes commands from a write-only, three-wire serial port: a serial clock, a serial data line and an active-low select. A host lowers select, shifts one command word in with the most significant bit first, and raises select. The block only listens. It oversamples all three lines with a faster system clock, finds the serial clock and select edges in that clock domain, and builds the word in a shift register.

A word is committed only when select rises after exactly 32 serial clock rising edges. The committed word then appears on a parallel output, together with a valid strobe that lasts one system clock cycle. A frame with fewer or more bits is dropped without a trace. The parallel output keeps the last committed word until the next good frame replaces it.

The block feeds a downstream command decoder, which reads the word when the strobe is high.

Top module: `cmd_word_rx`

## Requirements
- R1: While rst_n is low, word_o is 0 and word_vld_o is 0. A frame that is open when reset is applied is abandoned, so the select rise that ends it gives no strobe.
- R2: The first bit shifted in a frame ends up in bit 31 of word_o, and the last bit ends up in bit 0.
- R3: A data bit is taken only on a rising edge of ser_clk. Falling edges shift nothing.
- R4: Serial clock edges seen while ser_sel_n is high neither produce a strobe nor change word_o.
- R5: When ser_sel_n rises after exactly 32 bits, word_vld_o goes high for exactly one system clock cycle, and word_o holds the received word in that cycle.
- R6: When ser_sel_n rises after any count other than 32 (including 0), there is no strobe, and word_o keeps its previous value.
- R7: A frame with more than 32 bits is rejected whatever its length. The count never wraps back to 32 (for example, 33 or 64 bits are both rejected).
- R8: A falling edge of ser_sel_n restarts the bit count. A rejected short frame therefore does not affect the next frame.
- R9: word_vld_o is high in the third system clock cycle after the input change of ser_sel_n to high. The delay comes from two synchronizer stages and one output register.
- R10: word_o changes only in a cycle where word_vld_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_dat | input | 1 | Serial data, sent most significant bit first |
| ser_sel_n | input | 1 | Active-low frame select |
| word_o | output | 32 | Last committed command word |
| word_vld_o | output | 1 | One-cycle strobe marking a new committed word |

## Verification
A wrong bit count shows up the first time select rises: a strobe goes missing for a good frame, or an extra one appears for a bad frame, in the third cycle after the input change. A fault in the shift register or in the bit order shows up as a wrong word_o in that same strobe cycle. If a count is not cleared, or wraps past 32, the error appears only on the frame that follows an aborted or overlong one. The bench therefore runs short, long and zero-length frames directly before good ones.

// File: rtl/cmd_rx_pkg.sv
package cmd_rx_pkg;

  // Index of each serial line inside the synchronized vector
  localparam int LN_SCK = 0;
  localparam int LN_DAT = 1;
  localparam int LN_SEL = 2;
  localparam int LN_W   = 3;

  // Frame tracking: waiting for select, collecting bits, or too many bits
  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_TAKE  = 2'd1,
    FR_SPILL = 2'd2
  } frame_st_e;

endpackage

// File: rtl/cmd_rx_sync.sv
module cmd_rx_sync #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  for (genvar b = 0; b < W; b++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], async_i[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
      else        chain_q <= chain_d;
    end

    assign sync_o[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/cmd_rx_edge.sv
module cmd_rx_edge #(
  parameter int           W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl_i;
  end

  always_comb begin
    rise_o = lvl_i & ~prev_q;
    fall_o = ~lvl_i & prev_q;
  end

endmodule

// File: rtl/cmd_rx_frame.sv
module cmd_rx_frame
  import cmd_rx_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise_i,
  input  logic              sel_rise_i,
  input  logic              sel_fall_i,
  input  logic              dat_i,
  output logic [WORD_W-1:0] word_o,
  output logic              vld_o
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  frame_st_e         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [WORD_W-1:0] word_q;
  logic              vld_q, vld_d;
  logic              st_en, cnt_en, sh_en, word_en;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    vld_d   = 1'b0;
    st_en   = 1'b0;
    cnt_en  = 1'b0;
    sh_en   = 1'b0;
    word_en = 1'b0;
    if (sel_fall_i) begin
      st_d   = FR_TAKE;
      cnt_d  = '0;
      sh_d   = '0;
      st_en  = 1'b1;
      cnt_en = 1'b1;
      sh_en  = 1'b1;
    end else if (sel_rise_i) begin
      st_d  = FR_IDLE;
      st_en = 1'b1;
      if (st_q == FR_TAKE && cnt_q == CNT_FULL) begin
        word_en = 1'b1;
        vld_d   = 1'b1;
      end
    end else if (sck_rise_i && st_q == FR_TAKE) begin
      if (cnt_q == CNT_FULL) begin
        st_d  = FR_SPILL;
        st_en = 1'b1;
      end else begin
        cnt_d  = cnt_q + 1'b1;
        sh_d   = {sh_q[WORD_W-2:0], dat_i};
        cnt_en = 1'b1;
        sh_en  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FR_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      if (st_en)   st_q   <= st_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      if (sh_en)   sh_q   <= sh_d;
      if (word_en) word_q <= sh_q;
      vld_q <= vld_d;
    end
  end

  assign word_o = word_q;
  assign vld_o  = vld_q;

endmodule

// File: rtl/cmd_word_rx.sv
module cmd_word_rx
  import cmd_rx_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_sel_n,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o
);

  // Select idles high, clock and data idle low
  localparam logic [LN_W-1:0] SYNC_RST = LN_W'(1) << LN_SEL;
  localparam int              E_SCK    = 0;
  localparam int              E_SEL    = 1;

  logic [LN_W-1:0] raw_lines;
  logic [LN_W-1:0] lvl;
  logic [1:0]      edge_lvl;
  logic [1:0]      edge_rise;
  logic [1:0]      edge_fall;
  logic            sck_rise;
  logic            sel_rise;
  logic            sel_fall;
  logic            sel_hi_s;

  always_comb begin
    raw_lines         = '0;
    raw_lines[LN_SCK] = ser_clk;
    raw_lines[LN_DAT] = ser_dat;
    raw_lines[LN_SEL] = ser_sel_n;
  end

  cmd_rx_sync #(
    .W       (LN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (SYNC_RST)
  ) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_lines),
    .sync_o  (lvl)
  );

  assign edge_lvl = {lvl[LN_SEL], lvl[LN_SCK]};

  cmd_rx_edge #(
    .W       (2),
    .RST_VAL (2'b10)
  ) edge_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (edge_lvl),
    .rise_o (edge_rise),
    .fall_o (edge_fall)
  );

  assign sck_rise = edge_rise[E_SCK] & ~edge_fall[E_SCK];
  assign sel_rise = edge_rise[E_SEL];
  assign sel_fall = edge_fall[E_SEL];
  assign sel_hi_s = lvl[LN_SEL];

  cmd_rx_frame #(
    .WORD_W (WORD_W)
  ) frame_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck_rise_i (sck_rise),
    .sel_rise_i (sel_rise),
    .sel_fall_i (sel_fall),
    .dat_i      (lvl[LN_DAT]),
    .word_o     (word_o),
    .vld_o      (word_vld_o)
  );

endmodule

// File: rtl/cmd_word_rx_chk.sv
module cmd_word_rx_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] word_o,
  input logic              word_vld_o,
  input logic              sel_rise,
  input logic              sel_hi_s
);

  // R1: outputs quiet while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (word_o == '0 && !word_vld_o)
        else $error("reset state violated");
    end
  end

  // R5: strobe lasts one cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o |=> !word_vld_o);

  // R5: a strobe always follows a detected select rise
  a_r5_after_sel_rise: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o |-> $past(sel_rise));

  // R4: no strobe while the synchronized select is low
  a_r4_not_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o |-> sel_hi_s);

  // R10: the word moves only with a strobe
  a_r10_word_moves_with_vld: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_o) |-> word_vld_o);

endmodule

bind cmd_word_rx cmd_word_rx_chk #(.WORD_W(WORD_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .word_o     (word_o),
  .word_vld_o (word_vld_o),
  .sel_rise   (sel_rise),
  .sel_hi_s   (sel_hi_s)
);

// File: tb/cmd_word_rx_tb_top.sv
module cmd_word_rx_tb_top;

  localparam int H    = 6;
  localparam int NVEC = 10;

  localparam logic [31:0] VEC_DATA [NVEC] = '{
    32'hA5A5_5A5A, 32'h0000_0001, 32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678,
    32'hDEAD_BEEF, 32'hCAFE_F00D, 32'h0F0F_3C3C, 32'h7FFF_FFFE, 32'h0000_0000
  };
  localparam int VEC_BITS [NVEC] = '{32, 32, 32, 31, 33, 32, 0, 64, 32, 32};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ser_clk;
  logic        ser_dat;
  logic        ser_sel_n;
  logic [31:0] word_o;
  logic        word_vld_o;

  int          n_cmp = 0;
  int          n_bad = 0;
  logic [31:0] exp_word;

  always #2.5 clk = ~clk;

  cmd_word_rx dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_clk    (ser_clk),
    .ser_dat    (ser_dat),
    .ser_sel_n  (ser_sel_n),
    .word_o     (word_o),
    .word_vld_o (word_vld_o)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sel_down();
    ser_sel_n = 1'b0;
    wait_n(H);
  endtask

  task automatic shift_bits(input logic [31:0] d, input int n);
    logic [31:0] sh;
    sh = d;
    for (int i = 0; i < n; i++) begin
      ser_dat = sh[31];
      sh      = sh << 1;
      wait_n(H);
      ser_clk = 1'b1;
      wait_n(H);
      ser_clk = 1'b0;
    end
    wait_n(H);
  endtask

  task automatic sel_up_watch(output int pulses, output int lat, output logic [31:0] w);
    ser_sel_n = 1'b1;
    pulses    = 0;
    lat       = 0;
    w         = word_o;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (word_vld_o) begin
        pulses++;
        lat = k;
        w   = word_o;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int          p;
    int          l;
    logic [31:0] w;
    rst_n     = 1'b0;
    ser_clk   = 1'b0;
    ser_dat   = 1'b0;
    ser_sel_n = 1'b1;
    exp_word  = '0;
    wait_n(4);
    chk("R1 reset word", word_o, 32'h0);
    chk("R1 reset strobe", {31'h0, word_vld_o}, 32'h0);
    rst_n = 1'b1;
    wait_n(4);

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      sel_down();
      shift_bits(VEC_DATA[v], VEC_BITS[v]);
      sel_up_watch(p, l, w);
      if (VEC_BITS[v] == 32) begin
        exp_word = VEC_DATA[v];
        chk("R5 one strobe", p, 1);
        chk("R2/R3 word bits", w, exp_word);
        chk("R9 strobe latency", l, 3);
      end else if (VEC_BITS[v] > 32) begin
        chk("R7 overlong no strobe", p, 0);
        chk("R7 word held", word_o, exp_word);
      end else begin
        chk("R6 short no strobe", p, 0);
        chk("R6 word held", word_o, exp_word);
      end
      wait_n(H);
    end

    // R4: clocks with select high
    ser_dat = 1'b1;
    p = 0;
    for (int i = 0; i < 40; i++) begin
      ser_clk = 1'b1;
      wait_n(3);
      if (word_vld_o) p++;
      ser_clk = 1'b0;
      wait_n(3);
      if (word_vld_o) p++;
    end
    chk("R4 no strobe when deselected", p, 0);
    chk("R4 word unchanged", word_o, exp_word);

    // R8: aborted short frame, then good frame
    sel_down();
    shift_bits(32'hFFFF_0000, 16);
    sel_up_watch(p, l, w);
    chk("R8 aborted no strobe", p, 0);
    wait_n(H);
    sel_down();
    shift_bits(32'h1357_9BDF, 32);
    sel_up_watch(p, l, w);
    exp_word = 32'h1357_9BDF;
    chk("R8 next frame strobe", p, 1);
    chk("R8 next frame word", w, exp_word);
    wait_n(H);

    // R1: reset in the middle of a frame
    sel_down();
    shift_bits(32'hAAAA_AAAA, 10);
    rst_n = 1'b0;
    wait_n(2);
    chk("R1 mid-frame reset word", word_o, 32'h0);
    chk("R1 mid-frame reset strobe", {31'h0, word_vld_o}, 32'h0);
    rst_n = 1'b1;
    wait_n(2);
    exp_word = 32'h0;
    sel_up_watch(p, l, w);
    chk("R1 abandoned frame no strobe", p, 0);
    wait_n(H);
    sel_down();
    shift_bits(32'h2468_ACE0, 32);
    sel_up_watch(p, l, w);
    chk("R5 after reset strobe", p, 1);
    chk("R2 after reset word", w, 32'h2468_ACE0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule